// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals and the index mark of an incremental rotary encoder into a position count. It also reports the direction of the last step and keeps a sticky flag for counter roll-over. All three encoder inputs pass through two-flop synchronizers. After that, each change of a phase either moves the count up or down, or is ignored. The choice depends on the selected update rate (two or four counts per encoder cycle) and on which phase changed.

A three-bit mode field does three jobs:

- It switches the decoder off.
- It picks 2x or 4x counting.
- It chooses whether the count is cleared by the index mark or wraps against a programmable maximum.

A decimated pulse stream gives one pulse for every 1, 4, 16 or 64 decoded steps and feeds an external speed-measurement timer. When the decoder is active it owns the shared input pins, so an input-capture function that requests those pins has its enable held low.

Software reaches the block through a single-cycle write port and a combinational read port. The write port sets the control field, the maximum count and the position, and clears the error flag. The read port returns the status, the maximum count and the position.

Top module: `qenc_counter`

## Requirements
- R1: Mode codes 001 and 010 select 2x counting, and 101 and 110 select 4x counting. Codes 001 and 101 use index clearing; codes 010 and 110 use maximum-count wrapping. Every other code (000, 011, 100, 111) is off: the position does not change and the index mark has no effect.
- R2: In 4x modes, each change of exactly one phase moves the position by one.
- R3: In 2x modes, only changes of phase A move the position. A change of phase B alone leaves it unchanged.
- R4: The forward phase sequence (A,B) = 00, 10, 11, 01 counts up and sets the direction bit to 1. The reverse sequence counts down and sets the direction bit to 0. The direction bit updates on every counted step.
- R5: When both phases change in the same synchronized sample, the step is invalid and the position and direction bit stay unchanged.
- R6: In index modes, a rising edge of the synchronized index input clears the position to 0. In maximum-count modes the index input has no effect.
- R7: In maximum-count modes, counting up from a position equal to the maximum gives 0, and counting down from 0 gives the maximum. Both set the error flag.
- R8: In index modes, the position wraps at 16-bit limits: up from 0xFFFF gives 0, and down from 0 gives 0xFFFF. Both set the error flag.
- R9: Once set, the error flag stays at 1 until a write to address 3.
- R10: The velocity output gives one single-cycle pulse for every 1, 4, 16 or 64 counted steps, for reduction codes 00, 01, 10 and 11. Setting the velocity-disable control bit to 1 suppresses all pulses. The prescaler restarts from zero while the decoder is off or the pulses are disabled.
- R11: The capture enable output equals the capture request input while the mode is off, and is 0 while any valid mode is selected.
- R12: After reset, the position, maximum, direction bit, error flag, control field and velocity output are all 0. A phase change shows up on the position output three clock edges after it reaches the pins.
- R13: The write port decodes four addresses:
  - Address 0 writes the control field: bits [2:0] are the mode, bits [4:3] the reduction code, and bit 5 is velocity-disable.
  - Address 1 writes the maximum count.
  - Address 2 writes the position; this takes priority over counting.
  - Address 3 clears the error flag.

  On the read port, address 0 returns the error flag in bit 7, the direction bit in bit 6 and the control field in bits [5:0]. Address 1 returns the maximum count and address 2 returns the position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pha_i | input | 1 | Encoder phase A, asynchronous |
| phb_i | input | 1 | Encoder phase B, asynchronous |
| idx_i | input | 1 | Encoder index mark, asynchronous |
| cap_req_i | input | 1 | Capture function request for the shared pins |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 2 | Register address for read and write |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i |
| pos_o | output | CNT_W | Current position count |
| dir_o | output | 1 | Direction of the last counted step, 1 = forward |
| err_o | output | 1 | Sticky roll-over flag |
| vel_pulse_o | output | 1 | Decimated step pulse |
| cap_en_o | output | 1 | Capture enable after gating by the decoder |

## Verification
The bench builds the block with the defaults, CNT_W = 16 and PRE_W = 6. With these values the full 64-step reduction ratio fits in the prescaler, and the 16-bit wrap points lie where R8 states them. Loading the position through the write port brings both wrap points within a single step, so the tests need no long counting runs. A small maximum count of 3 makes the maximum-count wrap (R7) reachable in both directions within a few steps.

// File: rtl/qenc_pkg.sv
`timescale 1ns/1ps
package qenc_pkg;

    localparam int CTRL_W = 6;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_MAX    = 2'd1;
    localparam logic [1:0] ADDR_POS    = 2'd2;
    localparam logic [1:0] ADDR_ERRCLR = 2'd3;

    typedef struct packed {
        logic       vel_dis;
        logic [1:0] pdec;
        logic [2:0] mode;
    } ctrl_t;

    // exactly one of the two low mode bits set means a running mode
    function automatic logic mode_active(input logic [2:0] m);
        return m[1] ^ m[0];
    endfunction

    function automatic logic mode_quad(input logic [2:0] m);
        return m[2];
    endfunction

    function automatic logic mode_index(input logic [2:0] m);
        return m[0];
    endfunction

endpackage

// File: rtl/qenc_sync.sv
`timescale 1ns/1ps
module qenc_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] st_d, st_q;

        always_comb st_d = {st_q[0], d[i]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign q[i] = st_q[1];
    end
endmodule

// File: rtl/qenc_edge.sv
`timescale 1ns/1ps
module qenc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    input  logic idx,
    input  logic quad,
    output logic step,
    output logic up,
    output logic idx_rise
);
    typedef struct packed {
        logic a;
        logic b;
        logic idx;
    } prev_t;

    prev_t prev_d, prev_q;
    logic  a_chg, b_chg;

    always_comb begin
        prev_d   = '{a: a, b: b, idx: idx};
        a_chg    = a ^ prev_q.a;
        b_chg    = b ^ prev_q.b;
        // a single-phase change is valid; both at once is rejected
        step     = quad ? (a_chg ^ b_chg) : (a_chg & ~b_chg);
        up       = a_chg ? (a ^ b) : ~(a ^ b);
        idx_rise = idx & ~prev_q.idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/qenc_vel.sv
`timescale 1ns/1ps
module qenc_vel #(
    parameter int PRE_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       step,
    input  logic [1:0] pdec,
    output logic       pulse
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic             pulse;
    } vel_t;

    vel_t             v_d, v_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        // ratio 4**pdec, terminal value = ratio - 1
        for (int i = 0; i < PRE_W; i++) lim[i] = (i < 2 * int'(pdec));
        v_d       = v_q;
        v_d.pulse = 1'b0;
        if (!en) begin
            v_d.cnt = '0;
        end else if (step) begin
            if (v_q.cnt == lim) begin
                v_d.cnt   = '0;
                v_d.pulse = 1'b1;
            end else begin
                v_d.cnt = v_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign pulse = v_q.pulse;
endmodule

// File: rtl/qenc_counter.sv
`timescale 1ns/1ps
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pha_i,
    input  logic             phb_i,
    input  logic             idx_i,
    input  logic             cap_req_i,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    output logic [CNT_W-1:0] pos_o,
    output logic             dir_o,
    output logic             err_o,
    output logic             vel_pulse_o,
    output logic             cap_en_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] maxc;
        logic [CNT_W-1:0] pos;
        logic             dir;
        logic             err;
    } st_t;

    st_t        st_d, st_q;
    logic [2:0] sync_q;
    logic       step, up, idx_rise;
    logic       active, counting, roll;

    // signals exposed to the bound checker
    logic [2:0]       mode_cur;
    logic             vel_off;
    logic [CNT_W-1:0] max_cur;

    qenc_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({idx_i, phb_i, pha_i}),
        .q     (sync_q)
    );

    qenc_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .a        (sync_q[0]),
        .b        (sync_q[1]),
        .idx      (sync_q[2]),
        .quad     (mode_quad(st_q.ctrl.mode)),
        .step     (step),
        .up       (up),
        .idx_rise (idx_rise)
    );

    qenc_vel #(.PRE_W(PRE_W)) u_vel (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active & ~st_q.ctrl.vel_dis),
        .step  (counting),
        .pdec  (st_q.ctrl.pdec),
        .pulse (vel_pulse_o)
    );

    always_comb begin
        st_d     = st_q;
        roll     = 1'b0;
        active   = mode_active(st_q.ctrl.mode);
        counting = active & step;

        if (counting) st_d.dir = up;

        if (active && mode_index(st_q.ctrl.mode) && idx_rise) begin
            st_d.pos = '0;
        end else if (counting) begin
            if (up) begin
                if (mode_index(st_q.ctrl.mode) ? (st_q.pos == CNT_TOP)
                                               : (st_q.pos == st_q.maxc)) begin
                    st_d.pos = '0;
                    roll     = 1'b1;
                end else begin
                    st_d.pos = st_q.pos + 1'b1;
                end
            end else begin
                if (st_q.pos == '0) begin
                    st_d.pos = mode_index(st_q.ctrl.mode) ? CNT_TOP : st_q.maxc;
                    roll     = 1'b1;
                end else begin
                    st_d.pos = st_q.pos - 1'b1;
                end
            end
        end

        if (wr_en_i) begin
            case (addr_i)
                ADDR_CTRL:   st_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
                ADDR_MAX:    st_d.maxc = wdata_i;
                ADDR_POS:    st_d.pos  = wdata_i;
                default:     st_d.err  = 1'b0;
            endcase
        end
        if (roll) st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr_i)
            ADDR_CTRL: rdata_o = CNT_W'({st_q.err, st_q.dir, st_q.ctrl});
            ADDR_MAX:  rdata_o = st_q.maxc;
            ADDR_POS:  rdata_o = st_q.pos;
            default:   rdata_o = '0;
        endcase
    end

    assign pos_o    = st_q.pos;
    assign dir_o    = st_q.dir;
    assign err_o    = st_q.err;
    assign cap_en_o = cap_req_i & ~active;
    assign mode_cur = st_q.ctrl.mode;
    assign vel_off  = st_q.ctrl.vel_dis;
    assign max_cur  = st_q.maxc;
endmodule

// File: rtl/qenc_checker.sv
`timescale 1ns/1ps
module qenc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic             cap_req,
    input logic             cap_en,
    input logic             vel_pulse,
    input logic [2:0]       mode,
    input logic             vel_off,
    input logic             err,
    input logic [CNT_W-1:0] pos,
    input logic [CNT_W-1:0] maxc
);
    a_r11_cap_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> cap_req);

    a_r11_cap_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] ^ mode[0]) |-> !cap_en);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(wr_en && addr == 2'd3)) |=> err);

    a_r10_vel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        vel_off |=> !vel_pulse);

    a_r1_off_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mode[1] ^ mode[0]) && !wr_en) |=> $stable(pos));

    a_r7_match_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !mode[0] && !wr_en && pos <= maxc) |=> pos <= maxc);
endmodule

bind qenc_counter qenc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_i),
    .addr      (addr_i),
    .cap_req   (cap_req_i),
    .cap_en    (cap_en_o),
    .vel_pulse (vel_pulse_o),
    .mode      (mode_cur),
    .vel_off   (vel_off),
    .err       (err_o),
    .pos       (pos_o),
    .maxc      (max_cur)
);

// File: tb/qenc_counter_test.sv
`timescale 1ns/1ps
module qenc_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pha = 1'b0, phb = 1'b0, idx = 1'b0, cap_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, pos;
    logic        dir, err, vel, cap_en;

    int errors = 0;
    int checks = 0;
    int vel_cnt = 0;
    int ph = 0;        // position in gray cycle 0..3 = 00,10,11,01
    bit done = 0;

    always #2 clk = ~clk;

    qenc_counter uut (
        .clk(clk), .rst_n(rst_n), .pha_i(pha), .phb_i(phb), .idx_i(idx),
        .cap_req_i(cap_req), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .pos_o(pos), .dir_o(dir), .err_o(err),
        .vel_pulse_o(vel), .cap_en_o(cap_en)
    );

    always @(negedge clk) if (vel) vel_cnt++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic step(input bit fwd);
        ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
        pha = (ph == 1 || ph == 2);
        phb = (ph == 2 || ph == 3);
        repeat (5) @(negedge clk);
    endtask

    task automatic steps(input bit fwd, input int n);
        for (int i = 0; i < n; i++) step(fwd);
    endtask

    task automatic pulse_idx();
        @(negedge clk); idx = 1'b1;
        repeat (3) @(negedge clk); idx = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R12 reset pos", pos, 0);
        check("R12 reset dir/err/vel", {dir, err, vel}, 0);
        addr = 2'd0; #0.1;
        check("R12 reset ctrl read", rdata, 0);
        addr = 2'd1; #0.1;
        check("R12 reset max read", rdata, 0);
        addr = 2'd0;
    endtask

    task automatic t_latency();
        wr(2'd0, 16'h0005);
        @(negedge clk); pha = 1'b1; ph = 1;
        @(negedge clk); @(negedge clk);
        check("R12 no change after two edges", pos, 0);
        @(negedge clk);
        check("R12 change after three edges", pos, 1);
        repeat (3) @(negedge clk);
        wr(2'd2, 16'h0000);
    endtask

    task automatic t_x4();
        wr(2'd0, 16'h0005);
        steps(1, 4);
        check("R2 4x forward count", pos, 4);
        check("R4 forward dir", dir, 1);
        steps(0, 2);
        check("R2 4x reverse count", pos, 2);
        check("R4 reverse dir", dir, 0);
    endtask

    task automatic t_x2();
        wr(2'd0, 16'h0001);
        wr(2'd2, 16'h0000);
        steps(1, 4);
        check("R3 2x forward cycle", pos, 2);
        steps(0, 1);
        steps(0, 1);
        check("R3 2x reverse after B and A", pos, 1);
    endtask

    task automatic t_invalid();
        logic [15:0] p0;
        wr(2'd0, 16'h0005);
        while (ph != 0) step(1);
        p0 = pos;
        pha = 1'b1; phb = 1'b1; ph = 2;
        repeat (5) @(negedge clk);
        check("R5 double change ignored", pos, p0);
        pha = 1'b0; phb = 1'b0; ph = 0;
        repeat (5) @(negedge clk);
        check("R5 double change back ignored", pos, p0);
    endtask

    task automatic t_off();
        wr(2'd0, 16'h0005);
        wr(2'd2, 16'h0007);
        wr(2'd0, 16'h0000);
        steps(1, 3);
        pulse_idx();
        check("R1 mode 000 frozen", pos, 7);
        wr(2'd0, 16'h0004);
        steps(1, 3);
        check("R1 mode 100 frozen", pos, 7);
        wr(2'd0, 16'h0007);
        steps(0, 2);
        pulse_idx();
        check("R1 mode 111 frozen", pos, 7);
    endtask

    task automatic t_index();
        wr(2'd0, 16'h0005);
        steps(1, 2);
        check("R6 count before index", pos, 9);
        pulse_idx();
        check("R6 index clears", pos, 0);
        wr(2'd0, 16'h0006);
        wr(2'd1, 16'h0009);
        wr(2'd2, 16'h0004);
        pulse_idx();
        check("R6 index ignored in max mode", pos, 4);
    endtask

    task automatic t_match();
        wr(2'd0, 16'h0006);
        wr(2'd1, 16'h0003);
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h0000);
        steps(1, 3);
        check("R7 reaches max", {err, pos}, 32'h0000_0003);
        step(1);
        check("R7 up wrap to 0 with err", {err, pos}, 32'h0001_0000);
        steps(1, 2);
        check("R9 err stays set", err, 1);
        addr = 2'd0; #0.1;
        check("R13 status read err bit", rdata[7], 1);
        addr = 2'd1; #0.1;
        check("R13 max read", rdata, 3);
        addr = 2'd0;
        wr(2'd3, 16'h0000);
        check("R9 err cleared by write", err, 0);
        wr(2'd2, 16'h0000);
        step(0);
        check("R7 down from 0 to max with err", {err, pos}, 32'h0001_0003);
        wr(2'd3, 16'h0000);
    endtask

    task automatic t_wrap();
        wr(2'd0, 16'h0005);
        wr(2'd2, 16'hFFFF);
        step(1);
        check("R8 up wrap", {err, pos}, 32'h0001_0000);
        wr(2'd3, 16'h0000);
        step(0);
        check("R8 down wrap", {err, pos}, 32'h0001_FFFF);
        wr(2'd3, 16'h0000);
    endtask

    task automatic t_vel();
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h000D);          // 4x index, ratio 1:4
        vel_cnt = 0;
        steps(1, 8);
        check("R10 ratio 4", vel_cnt, 2);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h0005);          // ratio 1:1
        vel_cnt = 0;
        steps(1, 5);
        check("R10 ratio 1", vel_cnt, 5);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h0015);          // ratio 1:16
        vel_cnt = 0;
        steps(0, 16);
        check("R10 ratio 16", vel_cnt, 1);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h001D);          // ratio 1:64
        vel_cnt = 0;
        steps(1, 63);
        check("R10 ratio 64 before", vel_cnt, 0);
        step(1);
        check("R10 ratio 64 at", vel_cnt, 1);
        wr(2'd0, 16'h0025);          // disabled, ratio 1:1
        vel_cnt = 0;
        steps(1, 3);
        check("R10 disable bit suppresses", vel_cnt, 0);
    endtask

    task automatic t_cap();
        cap_req = 1'b1;
        wr(2'd0, 16'h0000);
        check("R11 off passes request", cap_en, 1);
        wr(2'd0, 16'h0005);
        check("R11 4x mode blocks", cap_en, 0);
        wr(2'd0, 16'h0002);
        check("R11 2x mode blocks", cap_en, 0);
        wr(2'd0, 16'h0007);
        check("R11 unused code passes", cap_en, 1);
        cap_req = 1'b0;
        @(negedge clk);
        check("R11 no request", cap_en, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_x4();
        t_x2();
        t_invalid();
        t_off();
        t_index();
        t_match();
        t_wrap();
        t_vel();
        t_cap();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule